// File: doc/BRIEF.md
# Startup Offset Calibration and Blanking Controller

This controller sits beside a 10-bit sampling converter. It learns the combined amplifier and converter offset once, each time a register-driven reset mode is released. While reset mode is held, the block is idle. When reset mode drops, a fixed-length calibration run starts by itself. Near the end of that run the controller averages a power-of-two window of converter samples. It stores the negated mean as a signed correction word and freezes it until the next release.

The offset DAC code is the sum of the frozen correction and a programmable black-level pedestal, kept at or above zero. The pedestal comes from a clamp register and is clipped into its legal range. A blanking input replaces the live sample on the digital output with that same pedestal, so downstream logic sees a clean black level while the analog front end is shielded.

Top module: `ocal_ctrl`

## Requirements
- R1: While `rst_mode` is 1, the counter holds at zero, `cal_done` is 0 and the correction is zero, so one cycle later `dac_code` equals the clipped clamp value.
- R2: The effective clamp value is `clamp_set` clipped to the range 14..76. Inputs below 14 give 14 and inputs above 76 give 76.
- R3: Calibration starts on the first clock edge with `rst_mode` at 0. The count reaches 40000 at edge 40000 after release, and `cal_done` rises at edge 40001. It then stays high until reset mode is entered again.
- R4: The correction is the negated floor of the mean of 256 samples, taken at edges 39745 through 40000 after release. Samples outside those edges have no effect on it.
- R5: `dac_code` is registered. It equals the effective clamp plus the signed correction, floored at 0 and capped at 1023.
- R6: Once `cal_done` is high, the correction is frozen, and later `adc_sample` values do not change `dac_code`.
- R7: Entering reset mode during a calibration aborts it. The next release restarts the count from zero, so `cal_done` rises only 40001 edges after that later release.
- R8: `sample_out` is registered, with this priority: if `blank_in` is 1 it is the effective clamp; otherwise, if `rst_mode` is 1, it is 0; otherwise it is `adc_sample`.
- R9: `blank_in` has no effect on which samples are averaged or on the learned correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_mode | input | 1 | Register reset-mode bit, active high, synchronous |
| adc_sample | input | 10 | Converter output code |
| clamp_set | input | 7 | Black-level clamp register value (before clipping) |
| blank_in | input | 1 | Pre-blanking input, active high |
| dac_code | output | 10 | Offset DAC code: clamp plus correction |
| sample_out | output | 10 | Gated digital sample output |
| cal_done | output | 1 | Calibration complete flag |

## Verification
Blanking and the averaging window can be active in the same cycle. The bench holds `blank_in` high through the second half of the 256-sample window. It then checks that the learned correction, seen through `dac_code`, still matches the mean of the raw samples, while `sample_out` was showing the pedestal. The cycle in which the correction loads is also the cycle in which `cal_done` rises. It is judged by sampling `cal_done` at edge 40000 and again at edge 40001, and by checking that `dac_code` changes exactly one edge later.

// File: rtl/ocal_pkg.sv
package ocal_pkg;
  localparam int SAMPLE_W = 10;
  localparam int DAC_W    = 10;
  localparam int CLAMP_W  = 7;
  localparam int CLAMP_LO = 14;
  localparam int CLAMP_HI = 76;
  localparam int CORR_W   = DAC_W + 1;
  localparam int SUM_W    = CORR_W + 2;

  typedef logic [SAMPLE_W-1:0]      sample_t;
  typedef logic [DAC_W-1:0]         dac_t;
  typedef logic [CLAMP_W-1:0]       clamp_t;
  typedef logic signed [CORR_W-1:0] corr_t;

  localparam clamp_t CLAMP_LO_C = clamp_t'(CLAMP_LO);
  localparam clamp_t CLAMP_HI_C = clamp_t'(CLAMP_HI);

  // Clip a raw clamp register value into the legal pedestal range.
  function automatic clamp_t clip_clamp(input clamp_t raw);
    clamp_t r;
    if (raw < CLAMP_LO_C)      r = CLAMP_LO_C;
    else if (raw > CLAMP_HI_C) r = CLAMP_HI_C;
    else                       r = raw;
    return r;
  endfunction

  // Signed correction that cancels a measured mean level.
  function automatic corr_t negate_mean(input sample_t mean);
    corr_t m;
    m = corr_t'({1'b0, mean});
    return -m;
  endfunction

  // Pedestal plus correction, limited to the DAC code range.
  function automatic dac_t sum_to_dac(input clamp_t clamp, input corr_t corr);
    logic [SUM_W-1:0] s;
    dac_t r;
    s = {{(SUM_W-CLAMP_W){1'b0}}, clamp} + {{(SUM_W-CORR_W){corr[CORR_W-1]}}, corr};
    if (s[SUM_W-1])               r = '0;
    else if (|s[SUM_W-2:DAC_W])   r = '1;
    else                          r = s[DAC_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/ocal_timer.sv
module ocal_timer
  import ocal_pkg::*;
#(
  parameter int CAL_CYCLES = 40000,
  parameter int WIN_LOG2   = 8
) (
  input  logic clk,
  input  logic rst_mode,
  output logic win_en,
  output logic load_en,
  output logic done
);
  localparam int CNT_W = $clog2(CAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END   = CNT_W'(CAL_CYCLES);
  localparam logic [CNT_W-1:0] WIN_START = CNT_W'(CAL_CYCLES - (1 << WIN_LOG2));

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             at_end;

  assign at_end  = (cnt_q == CNT_END);
  assign win_en  = !rst_mode && (cnt_q >= WIN_START) && !at_end;
  assign load_en = !rst_mode && at_end && !done_q;
  assign done    = done_q;

  always_ff @(posedge clk) begin
    if (rst_mode) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (!at_end) cnt_q <= cnt_q + 1'b1;
      if (at_end)  done_q <= 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst_mode)
    cnt_q <= CNT_END);                                                // R3
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (rst_mode)
    $rose(done_q) |-> $past(cnt_q) == CNT_END);                       // R3
  AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (rst_mode)
    load_en |=> !load_en);                                            // R6
endmodule

// File: rtl/ocal_accum.sv
module ocal_accum
  import ocal_pkg::*;
#(
  parameter int WIN_LOG2 = 8
) (
  input  logic    clk,
  input  logic    rst_mode,
  input  logic    win_en,
  input  logic    load_en,
  input  sample_t adc_sample,
  output corr_t   corr
);
  localparam int ACC_W = SAMPLE_W + WIN_LOG2;

  logic [ACC_W-1:0] acc_q;
  corr_t            corr_q;
  sample_t          mean;

  assign mean = acc_q[ACC_W-1:WIN_LOG2];
  assign corr = corr_q;

  always_ff @(posedge clk) begin
    if (rst_mode) begin
      acc_q  <= '0;
      corr_q <= '0;
    end else begin
      if (win_en)  acc_q  <= acc_q + ACC_W'(adc_sample);
      if (load_en) corr_q <= negate_mean(mean);
    end
  end

  AST_CORR_HOLD: assert property (@(posedge clk) disable iff (rst_mode)
    !load_en |=> $stable(corr_q));                                    // R6
  AST_CORR_NONPOS: assert property (@(posedge clk) disable iff (rst_mode)
    corr_q[CORR_W-1] || (corr_q == '0));                              // R4
endmodule

// File: rtl/ocal_outmux.sv
module ocal_outmux
  import ocal_pkg::*;
(
  input  logic    clk,
  input  logic    rst_mode,
  input  logic    blank_in,
  input  sample_t adc_sample,
  input  clamp_t  clamp_eff,
  input  corr_t   corr,
  output dac_t    dac_code,
  output sample_t sample_out
);
  dac_t    dac_q;
  sample_t smp_q;

  assign dac_code   = dac_q;
  assign sample_out = smp_q;

  always_ff @(posedge clk) begin
    dac_q <= sum_to_dac(clamp_eff, corr);
    if (blank_in)      smp_q <= SAMPLE_W'(clamp_eff);
    else if (rst_mode) smp_q <= '0;
    else               smp_q <= adc_sample;
  end

  AST_BLANK_WINS: assert property (@(posedge clk) disable iff (rst_mode)
    $past(blank_in) |-> sample_out == SAMPLE_W'($past(clamp_eff)));   // R8
endmodule

// File: rtl/ocal_ctrl.sv
module ocal_ctrl
  import ocal_pkg::*;
#(
  parameter int CAL_CYCLES = 40000,
  parameter int WIN_LOG2   = 8
) (
  input  logic        clk,
  input  logic        rst_mode,
  input  logic [9:0]  adc_sample,
  input  logic [6:0]  clamp_set,
  input  logic        blank_in,
  output logic [9:0]  dac_code,
  output logic [9:0]  sample_out,
  output logic        cal_done
);
  clamp_t clamp_eff;
  logic   win_en;
  logic   load_en;
  corr_t  corr;

  assign clamp_eff = clip_clamp(clamp_set);

  ocal_timer #(.CAL_CYCLES(CAL_CYCLES), .WIN_LOG2(WIN_LOG2)) u_timer (
    .clk(clk), .rst_mode(rst_mode), .win_en(win_en),
    .load_en(load_en), .done(cal_done)
  );

  ocal_accum #(.WIN_LOG2(WIN_LOG2)) u_accum (
    .clk(clk), .rst_mode(rst_mode), .win_en(win_en), .load_en(load_en),
    .adc_sample(adc_sample), .corr(corr)
  );

  ocal_outmux u_out (
    .clk(clk), .rst_mode(rst_mode), .blank_in(blank_in),
    .adc_sample(adc_sample), .clamp_eff(clamp_eff), .corr(corr),
    .dac_code(dac_code), .sample_out(sample_out)
  );

  AST_DAC_IDLE: assert property (@(posedge clk) disable iff (rst_mode)
    !$past(cal_done) |-> dac_code == DAC_W'($past(clamp_eff)));       // R1
  AST_CLAMP_RANGE: assert property (@(posedge clk)
    clamp_eff >= CLAMP_LO_C && clamp_eff <= CLAMP_HI_C);              // R2
endmodule

// File: tb/sim_ocal_ctrl.sv
module sim_ocal_ctrl;
  localparam int CAL = 40000;
  localparam int WIN = 256;

  logic       clk = 1'b0;
  logic       rst_mode = 1'b1;
  logic [9:0] adc_sample = '0;
  logic [6:0] clamp_set = 7'd40;
  logic       blank_in = 1'b0;
  logic [9:0] dac_code;
  logic [9:0] sample_out;
  logic       cal_done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ocal_ctrl u0 (
    .clk(clk), .rst_mode(rst_mode), .adc_sample(adc_sample),
    .clamp_set(clamp_set), .blank_in(blank_in), .dac_code(dac_code),
    .sample_out(sample_out), .cal_done(cal_done)
  );

  // fields: rst, blank, adc, clamp_set, expected sample_out, expected dac_code
  localparam logic [38:0] VEC [10] = '{
    {1'b1, 1'b0, 10'd300,  7'd40,  10'd0,    10'd40},
    {1'b1, 1'b1, 10'd300,  7'd40,  10'd40,   10'd40},
    {1'b1, 1'b1, 10'd300,  7'd5,   10'd14,   10'd14},
    {1'b1, 1'b0, 10'd999,  7'd90,  10'd0,    10'd76},
    {1'b0, 1'b0, 10'd300,  7'd40,  10'd300,  10'd40},
    {1'b0, 1'b1, 10'd300,  7'd40,  10'd40,   10'd40},
    {1'b0, 1'b0, 10'd1023, 7'd76,  10'd1023, 10'd76},
    {1'b0, 1'b1, 10'd0,    7'd120, 10'd76,   10'd76},
    {1'b0, 1'b0, 10'd0,    7'd14,  10'd0,    10'd14},
    {1'b0, 1'b1, 10'd512,  7'd13,  10'd14,   10'd14}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // Vector table walk
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rst_mode   = VEC[i][38];
      blank_in   = VEC[i][37];
      adc_sample = VEC[i][36:27];
      clamp_set  = VEC[i][26:20];
      @(negedge clk);
      check("R8 sample_out", int'(sample_out), int'(VEC[i][19:10]));
      check("R2 dac_code clamp", int'(dac_code), int'(VEC[i][9:0]));
    end

    // R1: reset state
    @(negedge clk);
    rst_mode = 1'b1; blank_in = 1'b0; clamp_set = 7'd40; adc_sample = 10'd900;
    repeat (2) @(negedge clk);
    check("R1 done low in reset", int'(cal_done), 0);
    check("R1 dac equals clamp in reset", int'(dac_code), 40);
    check("R1 sample zero in reset", int'(sample_out), 0);

    // Calibration run 1: junk outside window, 20/27 halves, blanking in window
    rst_mode = 1'b0;
    repeat (CAL - WIN) @(posedge clk);
    @(negedge clk); adc_sample = 10'd20;
    repeat (WIN / 2) @(posedge clk);
    @(negedge clk); adc_sample = 10'd27; blank_in = 1'b1;   // R9
    repeat (WIN / 2) @(posedge clk);
    @(negedge clk);
    check("R9 blank output in window", int'(sample_out), 40);
    adc_sample = 10'd1000; blank_in = 1'b0;
    check("R3 done low at count end", int'(cal_done), 0);
    @(negedge clk);
    check("R3 done high next edge", int'(cal_done), 1);
    check("R8 live sample", int'(sample_out), 1000);
    check("R5 dac before load visible", int'(dac_code), 40);
    @(negedge clk);
    check("R4 R9 correction mean 23", int'(dac_code), 17);
    adc_sample = 10'd0;
    repeat (50) @(negedge clk);
    check("R6 frozen correction", int'(dac_code), 17);
    check("R3 done stays high", int'(cal_done), 1);
    clamp_set = 7'd100;
    repeat (2) @(negedge clk);
    check("R5 R2 clamp above range", int'(dac_code), 53);
    clamp_set = 7'd3; blank_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 floor at zero", int'(dac_code), 0);
    check("R8 blank uses clipped clamp", int'(sample_out), 14);
    blank_in = 1'b0;

    // R7: abort then restart
    rst_mode = 1'b1; clamp_set = 7'd30;
    repeat (2) @(negedge clk);
    check("R1 done cleared on re-entry", int'(cal_done), 0);
    check("R1 correction cleared", int'(dac_code), 30);
    rst_mode = 1'b0; adc_sample = 10'd5;
    repeat (1000) @(posedge clk);
    @(negedge clk); rst_mode = 1'b1;
    repeat (2) @(negedge clk);
    rst_mode = 1'b0;
    repeat (CAL) @(posedge clk);
    @(negedge clk);
    check("R7 restarted count not done", int'(cal_done), 0);
    @(negedge clk);
    check("R7 done after full restart", int'(cal_done), 1);
    @(negedge clk);
    check("R4 correction mean 5", int'(dac_code), 25);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule